// File: doc/BRIEF.md
# Sequence-Rearmed Watchdog Timer

This block supervises software by counting bus clock cycles. Once software has picked a nonzero timeout rate, the count runs freely. Software must rearm the timer before the count reaches the selected period. Rearming takes two writes to the arm register: 0x55 and then 0xAA. No single write restarts the count. If the period runs out, or if the arm register receives anything that breaks the two-value sequence, the block raises a reset request for exactly one cycle.

The control register can be written once after reset. After that write the rate is fixed until the next reset, so stray code cannot quietly turn supervision off. Every request also sets a sticky cause bit, one for an expired period and one for a broken sequence. These bits survive the ordinary reset and clear only on the power-on reset input. Software can read them after restart to learn why the system was reset.

Top module: `sw_watchdog`

## Requirements
- R1: After a reset with both `rst_n` and `por_n` low, `rst_req` is 0, `rate_o` is 0 and `cause` is 0.
- R2: With a rate of 0, which is the value after reset and is also a writable value, the block never requests a reset. While disabled, writes to the arm register have no effect: no request, no cause change.
- R3: With rate k (1..7) written to the control register, `rst_req` goes high for one cycle 2^(BASE_EXP+STEP_EXP*(k-1)) cycles after the clock edge that captured the write. Without rearming, it goes high again every such period.
- R4: A write of 0x55 followed by a write of 0xAA to the arm register (`wr_addr`=1) restarts the count. The next timeout comes one full period after the edge that captured the 0xAA.
- R5: A 0x55 write alone does not restart the count. The block waits for 0xAA for as many idle cycles as it takes, and a timeout keeps its original deadline meanwhile.
- R6: While enabled, an arm write with any value other than 0x55 as the first value of the sequence raises `rst_req` in the cycle after the write edge and sets `cause[1]`.
- R7: While enabled, an arm write directly after 0x55 with any value other than 0xAA raises `rst_req` in the cycle after the write edge and sets `cause[1]`. The sequence then starts over.
- R8: The control register (`wr_addr`=0) takes only the first write after reset. Later writes change neither `rate_o` nor the timeout period.
- R9: `cause[0]` (expired period) and `cause[1]` (broken sequence) are set by the request that fires. They stay set while `rst_n` is pulsed and clear only when `por_n` is low.
- R10: After a timeout request, the count starts again from zero.
- R11: The rate is taken from `wr_data[2:0]` of a control write. Bits 7..3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously upstream |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears the cause bits only |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 the arm register |
| wr_data | input | 8 | Write data |
| rate_o | output | RATE_W | Read-back of the locked rate select |
| rst_req | output | 1 | One-cycle reset request |
| cause | output | 2 | Sticky request causes: bit 0 period expired, bit 1 broken sequence |

## Verification
Corruption of the sequence state shows at the ports within one write. A lost pending state turns a correct 0xAA into a request. A stuck pending state lets a single 0xAA rearm, and the following period then comes out longer than expected. A wrong terminal count or a counter that is not cleared shows up as a request at the wrong cycle, so each rate's first and second timeouts are timed exactly. Sweeping every byte value in both sequence positions, together with the write-once and sticky-cause checks across `rst_n` and `por_n` pulses, exposes any decode slip within a few cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int DATA_W = 8;

  // arm register key values, checked in this order
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

  // register select decode
  localparam logic REG_CFG = 1'b0;
  localparam logic REG_ARM = 1'b1;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_PEND
  } seq_state_e;

  typedef struct packed {
    logic seq_err;
    logic expired;
  } cause_t;

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic [RATE_W-1:0] wr_rate,
  output logic [RATE_W-1:0] rate_q,
  output logic              enable
);

  logic              locked_q;
  logic              load;
  logic [RATE_W-1:0] rate_d;
  logic              locked_d;

  always_comb begin
    load     = wr_cfg && !locked_q;
    rate_d   = wr_rate;
    locked_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= '0;
      locked_q <= 1'b0;
    end else if (load) begin
      rate_q   <= rate_d;
      locked_q <= locked_d;
    end
  end

  assign enable = (rate_q != '0);

  // R8: once locked, the rate never moves again until reset
  a_r8_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(rate_q));

endmodule

// File: rtl/wdog_seq_fsm.sv
module wdog_seq_fsm
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic [DATA_W-1:0] arm_data,
  output logic              restart,
  output logic              seq_err
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    seq_err = 1'b0;
    if (arm_wr) begin
      case (state_q)
        SEQ_IDLE: begin
          if (arm_data == KEY_FIRST) state_d = SEQ_PEND;
          else                       seq_err = 1'b1;
        end
        SEQ_PEND: begin
          state_d = SEQ_IDLE;
          if (arm_data == KEY_SECOND) restart = 1'b1;
          else                        seq_err = 1'b1;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R5: the pending state is entered only from an accepted first key
  a_r5_pend_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == SEQ_PEND) |-> $past(arm_wr && (arm_data == KEY_FIRST)));

endmodule

// File: rtl/wdog_period_ctr.sv
module wdog_period_ctr #(
  parameter int RATE_W   = 3,
  parameter int BASE_EXP = 12,
  parameter int STEP_EXP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  input  logic              restart,
  output logic              expire
);

  localparam int NSEL  = 2 ** RATE_W;
  localparam int CNT_W = BASE_EXP + STEP_EXP * (NSEL - 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ld;
  logic [NSEL-1:0]  hit_vec;

  assign hit_vec[0] = 1'b0;

  genvar k;
  for (k = 1; k < NSEL; k++) begin : g_term
    localparam int EXP_K = BASE_EXP + STEP_EXP * (k - 1);
    localparam logic [CNT_W-1:0] TERM_K = CNT_W'((64'd1 << EXP_K) - 64'd1);
    assign hit_vec[k] = (cnt_q == TERM_K);
  end

  assign expire = en && hit_vec[rate];

  always_comb begin
    cnt_ld = en || (cnt_q != '0);
    if (!en || restart || expire) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  // R2: a disabled timer holds its count at zero
  a_r2_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  // R10: a timeout leaves the count at zero on the next cycle
  a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));

endmodule

// File: rtl/sw_watchdog.sv
module sw_watchdog
  import wdog_pkg::*;
#(
  parameter int RATE_W   = 3,
  parameter int BASE_EXP = 12,
  parameter int STEP_EXP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate_o,
  output logic              rst_req,
  output logic [1:0]        cause
);

  logic   wr_cfg, arm_wr, enable;
  logic   restart, seq_err, expire;
  logic   req_d;
  cause_t cause_q, cause_d;
  logic   cause_ld;

  assign wr_cfg = wr_en && (wr_addr == REG_CFG);
  assign arm_wr = wr_en && (wr_addr == REG_ARM) && enable;

  wdog_cfg_reg #(.RATE_W(RATE_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cfg  (wr_cfg),
    .wr_rate (wr_data[RATE_W-1:0]),
    .rate_q  (rate_o),
    .enable  (enable)
  );

  wdog_seq_fsm u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_wr   (arm_wr),
    .arm_data (wr_data),
    .restart  (restart),
    .seq_err  (seq_err)
  );

  wdog_period_ctr #(
    .RATE_W   (RATE_W),
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .rate    (rate_o),
    .restart (restart),
    .expire  (expire)
  );

  always_comb begin
    req_d           = expire || seq_err;
    cause_ld        = req_d;
    cause_d         = cause_q;
    cause_d.expired = cause_q.expired || expire;
    cause_d.seq_err = cause_q.seq_err || seq_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= req_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cause_q <= '0;
    else if (cause_ld) cause_q <= cause_d;
  end

  assign cause = cause_q;

  // R9: cause bits are sticky while power-on reset stays released
  a_r9_expired_sticky: assert property (@(posedge clk) disable iff (!por_n)
    cause[0] |=> cause[0]);
  a_r9_seq_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
    cause[1] |=> cause[1]);

  // R6: every request leaves a recorded cause behind
  a_r6_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |-> (cause != 2'b00));

  // R2: a rate of zero over the previous cycle means no request
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate_o == '0) && $past(rate_o == '0)) |-> !rst_req);

endmodule

// File: tb/tb_sw_watchdog.sv
`timescale 1ns/1ps
module tb_sw_watchdog;

  localparam int BASE = 4;
  localparam int STEP = 1;

  logic       clk = 1'b0;
  logic       rst_n, por_n, wr_en, wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rate_o;
  logic       rst_req;
  logic [1:0] cause;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sw_watchdog #(.RATE_W(3), .BASE_EXP(BASE), .STEP_EXP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rate_o(rate_o), .rst_req(rst_req), .cause(cause)
  );

  function automatic int period(input int k);
    return 1 << (BASE + STEP * (k - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit por);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
  endtask

  task automatic wr(input logic addr, input logic [7:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_req(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rst_req && n < limit);
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; por_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    @(negedge clk);
    do_reset(1);

    // R1 reset state
    chk(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
    chk(rate_o == 3'd0, "R1 rate", rate_o, 0);
    chk(cause == 2'b00, "R1 cause", cause, 0);

    // R2 arm writes ignored before any control write
    wr(1'b1, 8'h13);
    chk(rst_req == 1'b0 && cause == 2'b00, "R2 arm while disabled", rst_req, 0);

    // R2 / R8: lock at zero, later enable attempt ignored
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h03);
    chk(rate_o == 3'd0, "R8 locked at zero", rate_o, 0);
    wr(1'b1, 8'h77);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h00);
    chk(cause == 2'b00, "R2 cause untouched", cause, 0);
    quiet(2200, "R2 no request when disabled");

    // R3 / R10 every rate: first and second timeouts
    for (int k = 1; k < 8; k++) begin
      do_reset(0);
      wr(1'b0, 8'(k));
      chk(rate_o == 3'(k), "R3 rate readback", rate_o, k);
      wait_req(period(k) + 8, n);
      chk(n == period(k), "R3 first timeout", n, period(k));
      @(negedge clk);
      chk(rst_req == 1'b0, "R3 one-cycle pulse", rst_req, 0);
      wait_req(period(k) + 8, n);
      chk(n == period(k) - 1, "R10 periodic timeout", n, period(k) - 1);
      chk(cause[0] == 1'b1, "R9 expired bit", cause, 1);
    end

    // R4 rearm restarts; repeated rearms keep it quiet
    do_reset(0);
    wr(1'b0, 8'd3);
    for (int r = 0; r < 5; r++) begin
      repeat (40) @(negedge clk);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      chk(rst_req == 1'b0, "R4 valid rearm no request", rst_req, 0);
    end
    wait_req(period(3) + 8, n);
    chk(n == period(3), "R4 timeout after rearm", n, period(3));

    // R5 first key alone keeps the old deadline
    do_reset(0);
    wr(1'b0, 8'd2);
    wr(1'b1, 8'h55);
    wait_req(period(2) + 8, n);
    chk(n == period(2) - 1, "R5 first key no restart", n, period(2) - 1);

    // R5 pending survives idle cycles
    do_reset(0);
    wr(1'b0, 8'd2);
    wr(1'b1, 8'h55);
    quiet(10, "R5 pending idle");
    wr(1'b1, 8'hAA);
    chk(rst_req == 1'b0, "R5 late second key", rst_req, 0);
    wait_req(period(2) + 8, n);
    chk(n == period(2), "R5 restart on late key", n, period(2));

    // R6 sweep over the first value
    for (int v = 0; v < 256; v++) begin
      do_reset(1);
      wr(1'b0, 8'd7);
      wr(1'b1, 8'(v));
      chk(rst_req == (v != 8'h55), "R6 first value", rst_req, v != 8'h55);
      chk(cause == ((v != 8'h55) ? 2'b10 : 2'b00), "R6 cause", cause,
          (v != 8'h55) ? 2 : 0);
    end

    // R7 sweep over the value after the first key, then recovery
    for (int v = 0; v < 256; v++) begin
      do_reset(1);
      wr(1'b0, 8'd7);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'(v));
      chk(rst_req == (v != 8'hAA), "R7 second value", rst_req, v != 8'hAA);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      chk(rst_req == 1'b0, "R7 sequence restarts", rst_req, 0);
    end

    // R8 second control write ignored
    do_reset(0);
    wr(1'b0, 8'd2);
    wr(1'b0, 8'd5);
    chk(rate_o == 3'd2, "R8 write-once rate", rate_o, 2);
    wait_req(period(5) + 8, n);
    chk(n == period(2) - 1, "R8 period unchanged", n, period(2) - 1);

    // R11 upper control bits ignored
    do_reset(0);
    wr(1'b0, 8'hF9);
    chk(rate_o == 3'd1, "R11 field decode", rate_o, 1);
    wait_req(period(1) + 8, n);
    chk(n == period(1), "R11 period", n, period(1));

    // R9 sticky across rst_n, cleared by por_n
    do_reset(1);
    chk(cause == 2'b00, "R9 cleared by por", cause, 0);
    wr(1'b0, 8'd1);
    wait_req(period(1) + 8, n);
    chk(cause == 2'b01, "R9 expired recorded", cause, 1);
    do_reset(0);
    chk(cause == 2'b01, "R9 survives rst_n", cause, 1);
    wr(1'b0, 8'd7);
    wr(1'b1, 8'h00);
    chk(cause == 2'b11, "R9 both causes", cause, 3);
    do_reset(0);
    chk(cause == 2'b11, "R9 both survive rst_n", cause, 3);
    do_reset(1);
    chk(cause == 2'b00, "R9 por clears", cause, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule